// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Sign/Zero/Overflow/Carry Status

This block combines a 32-bit combinational arithmetic-logic unit with a four-bit status register. Two operands and a six-bit operation code produce a result in the same cycle. The result covers addition, subtraction, low-word multiply, unsigned divide, the bitwise operations and the logical shifts. When the flag-update enable is high at a rising clock edge, the status register captures four flags derived from that result and from the operands.

The flags follow one fixed set of rules for every operation. The negative flag copies the result's top bit. The zero flag marks an all-zero result. The overflow flag applies the signed-addition overflow test to A, B and the result. The carry flag is the carry-out of the unsigned sum A+B. This holds even when the operation is not an addition, so a user must not read the overflow or carry flag as describing, for example, a subtraction.

A separate operand selector returns one of four external register values, or one of the stored flags zero-extended to 32 bits. This lets a surrounding datapath feed a flag back into the unit as an operand.

Top module: `alu_flags_unit`

## Requirements
- R1: Code 0 gives A+B and code 1 gives A-B, both modulo 2^32.
- R2: Code 2 gives the low 32 bits of the product A*B.
- R3: Code 3 gives the unsigned quotient A/B. When B is zero, the result is 0xFFFFFFFF.
- R4: Code 4 gives A AND B, code 5 gives A OR B, code 6 gives A XOR B, and code 7 gives the bitwise inverse of A.
- R5: Code 8 shifts A left logically by B[4:0], and code 9 shifts A right logically by B[4:0].
- R6: Every code from 10 to 63 gives a result of zero.
- R7: flags_o packs N in bit 3, Z in bit 2, V in bit 1 and C in bit 0. At a rising edge with flag_we_i high, N takes bit 31 of the result and Z is set exactly when the result is zero.
- R8: At such an edge, V is set exactly when A[31] equals B[31] and the result's bit 31 differs from A[31], whatever the operation.
- R9: At such an edge, C is set exactly when the 33-bit unsigned sum A+B exceeds 0xFFFFFFFF, whatever the operation.
- R10: At a rising edge with flag_we_i low, flags_o keeps its value.
- R11: While rst_ni is low, flags_o is 0.
- R12: The selector output behaves as follows:
  - codes 0 to 3 pass reg_vals_i[code];
  - codes 4, 5, 6 and 7 pass N, Z, V and C, zero-extended;
  - codes 8 to 31 give zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 32 | Operand A |
| op_b_i | input | 32 | Operand B |
| op_code_i | input | 6 | Operation code |
| flag_we_i | input | 1 | Flag-update enable |
| result_o | output | 32 | Combinational result |
| flags_o | output | 4 | Stored flags {N,Z,V,C} |
| reg_vals_i | input | 4x32 | Four register values for the selector |
| sel_code_i | input | 5 | Selector code |
| sel_data_o | output | 32 | Selector output |

## Verification
The assertions take for granted that the operands, the operation code and the enable stay stable between rising edges. They also assume none of these inputs carries unknown values while reset is released. This lets the flag checks compare the registered flags with the result sampled one edge earlier. The stimulus changes every input only on the falling clock edge. It draws operands from a mix of boundary words (zero, one, all ones, the sign extremes) and free random words. It draws operation codes from the whole six-bit range, so undefined codes also occur.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned OP_W     = 6;
    localparam int unsigned SEL_W    = 5;
    localparam int unsigned NUM_REGS = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 6'd0,
        OP_SUB = 6'd1,
        OP_MUL = 6'd2,
        OP_DIV = 6'd3,
        OP_AND = 6'd4,
        OP_OR  = 6'd5,
        OP_XOR = 6'd6,
        OP_NOT = 6'd7,
        OP_SHL = 6'd8,
        OP_SHR = 6'd9
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_flags_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [OP_W-1:0]  op_i,
    output logic [WIDTH-1:0] res_o
);
    localparam int unsigned SH_W = $clog2(WIDTH);

    alu_op_e          op;
    logic [WIDTH-1:0] prod;
    logic [WIDTH-1:0] quot;
    logic [SH_W-1:0]  shamt;

    assign op    = alu_op_e'(op_i);
    assign shamt = b_i[SH_W-1:0];

    // low word of the product only
    always_comb begin
        prod = a_i * b_i;
    end

    // unsigned quotient, saturating to all ones on a zero divisor
    always_comb begin
        if (b_i == '0) begin
            quot = '1;
        end else begin
            quot = a_i / b_i;
        end
    end

    always_comb begin
        unique case (op)
            OP_ADD:  res_o = a_i + b_i;
            OP_SUB:  res_o = a_i - b_i;
            OP_MUL:  res_o = prod;
            OP_DIV:  res_o = quot;
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_NOT:  res_o = ~a_i;
            OP_SHL:  res_o = a_i << shamt;
            OP_SHR:  res_o = a_i >> shamt;
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_flags_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] res_i,
    input  logic             we_i,
    output flags_t           flags_o
);
    typedef struct packed {
        flags_t flg;
    } state_t;

    state_t         st_d, st_q;
    logic [WIDTH:0] sum_ext;

    always_comb begin
        sum_ext = {1'b0, a_i} + {1'b0, b_i};
        st_d    = st_q;
        if (we_i) begin
            st_d.flg.n = res_i[WIDTH-1];
            st_d.flg.z = (res_i == '0);
            st_d.flg.v = (a_i[WIDTH-1] == b_i[WIDTH-1]) &&
                         (res_i[WIDTH-1] != a_i[WIDTH-1]);
            st_d.flg.c = sum_ext[WIDTH];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flg;

    // R10
    flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_i |=> $stable(flags_o));

    // R7
    neg_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> flags_o.n == $past(res_i[WIDTH-1]));

endmodule

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
    import alu_flags_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W,
    parameter int unsigned NREGS = NUM_REGS,
    parameter int unsigned SW    = SEL_W
) (
    input  logic [NREGS-1:0][WIDTH-1:0] regs_i,
    input  flags_t                      flags_i,
    input  logic [SW-1:0]               sel_i,
    output logic [WIDTH-1:0]            data_o
);
    localparam int unsigned NFLAGS = 4;

    logic [NFLAGS-1:0] flag_vec;
    assign flag_vec = flags_i;

    always_comb begin
        data_o = '0;
        for (int k = 0; k < NREGS; k++) begin
            if (sel_i == SW'(k)) begin
                data_o = regs_i[k];
            end
        end
        for (int k = 0; k < NFLAGS; k++) begin
            if (sel_i == SW'(NREGS + k)) begin
                data_o = WIDTH'(flag_vec[NFLAGS-1-k]);
            end
        end
    end

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_flags_pkg::*;
(
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic [DATA_W-1:0]              op_a_i,
    input  logic [DATA_W-1:0]              op_b_i,
    input  logic [OP_W-1:0]                op_code_i,
    input  logic                           flag_we_i,
    output logic [DATA_W-1:0]              result_o,
    output logic [3:0]                     flags_o,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] reg_vals_i,
    input  logic [SEL_W-1:0]               sel_code_i,
    output logic [DATA_W-1:0]              sel_data_o
);
    flags_t flg;

    alu_datapath #(.WIDTH(DATA_W)) u_datapath (
        .a_i   (op_a_i),
        .b_i   (op_b_i),
        .op_i  (op_code_i),
        .res_o (result_o)
    );

    alu_flag_reg #(.WIDTH(DATA_W)) u_flag_reg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .a_i     (op_a_i),
        .b_i     (op_b_i),
        .res_i   (result_o),
        .we_i    (flag_we_i),
        .flags_o (flg)
    );

    alu_operand_sel #(.WIDTH(DATA_W), .NREGS(NUM_REGS), .SW(SEL_W)) u_sel (
        .regs_i  (reg_vals_i),
        .flags_i (flg),
        .sel_i   (sel_code_i),
        .data_o  (sel_data_o)
    );

    assign flags_o = flg;

    // R6
    undef_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_code_i > OP_W'(9)) |-> (result_o == '0));

    // R3
    div_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_code_i == OP_W'(3) && op_b_i == '0) |-> (result_o == '1));

    // R7
    zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_we_i |=> (flags_o[2] == ($past(result_o) == '0)));

    // R12
    sel_high_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_code_i > SEL_W'(7)) |-> (sel_data_o == '0));

    // R12
    sel_zflag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_code_i == SEL_W'(5)) |-> (sel_data_o == {{(DATA_W-1){1'b0}}, flags_o[2]}));

endmodule

// File: tb/test_alu_flags_unit.sv
module test_alu_flags_unit;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       a = '0, b = '0;
    logic [5:0]        op = '0;
    logic              we = 1'b0;
    logic [31:0]       res;
    logic [3:0]        flg;
    logic [3:0][31:0]  regs = '0;
    logic [4:0]        sel = '0;
    logic [31:0]       sel_data;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;
    logic [3:0] exp_flg = 4'h0;

    always #4 clk = ~clk;

    alu_flags_unit i_alu_flags_unit (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .op_a_i     (a),
        .op_b_i     (b),
        .op_code_i  (op),
        .flag_we_i  (we),
        .result_o   (res),
        .flags_o    (flg),
        .reg_vals_i (regs),
        .sel_code_i (sel),
        .sel_data_o (sel_data)
    );

    function automatic logic [31:0] model_res(logic [31:0] x, logic [31:0] y, logic [5:0] c);
        logic [63:0] p;
        case (c)
            6'd0: return x + y;
            6'd1: return x - y;
            6'd2: begin p = {32'h0, x} * {32'h0, y}; return p[31:0]; end
            6'd3: return (y == 0) ? 32'hFFFF_FFFF : x / y;
            6'd4: return x & y;
            6'd5: return x | y;
            6'd6: return x ^ y;
            6'd7: return ~x;
            6'd8: return x << y[4:0];
            6'd9: return x >> y[4:0];
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [3:0] model_flg(logic [31:0] x, logic [31:0] y, logic [31:0] r);
        logic [32:0] s;
        s = {1'b0, x} + {1'b0, y};
        return {r[31], (r == 0), (x[31] == y[31]) && (r[31] != x[31]), s[32]};
    endfunction

    function automatic string req_of(logic [5:0] c);
        if (c <= 1) return "R1";
        if (c == 2) return "R2";
        if (c == 3) return "R3";
        if (c <= 7) return "R4";
        if (c <= 9) return "R5";
        return "R6";
    endfunction

    function automatic logic [31:0] model_sel(logic [4:0] s, logic [3:0][31:0] rv, logic [3:0] f);
        if (s < 4) return rv[s[1:0]];
        if (s < 8) return {31'h0, f[3 - (s - 4)]};
        return 32'h0;
    endfunction

    function automatic logic [31:0] pick_word();
        case ($urandom_range(0, 7))
            0: return 32'h0;
            1: return 32'h1;
            2: return 32'hFFFF_FFFF;
            3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;
            default: return $urandom();
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(logic [31:0] x, logic [31:0] y, logic [5:0] c, logic w);
        logic [31:0] er;
        @(negedge clk);
        a = x; b = y; op = c; we = w;
        #1;
        er = model_res(x, y, c);
        check(req_of(c), res, er, "result");
        if (w) exp_flg = model_flg(x, y, er);
        @(negedge clk);
        we = 1'b0;
        #1;
        // R7 R8 R9 R10
        check(w ? "R7/R8/R9" : "R10", {28'h0, flg}, {28'h0, exp_flg}, "flags");
    endtask

    task automatic run_sel(logic [4:0] s);
        @(negedge clk);
        sel = s;
        for (int k = 0; k < 4; k++) regs[k] = $urandom();
        #1;
        check("R12", sel_data, model_sel(s, regs, exp_flg), "selector");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (2) @(negedge clk);
        // R11
        check("R11", {28'h0, flg}, 32'h0, "reset flags");
        rst_n = 1'b1;

        // directed corners
        run_op(32'hFFFF_FFFF, 32'h1, 6'd0, 1'b1);   // R1, R9 carry, R7 zero
        run_op(32'h7FFF_FFFF, 32'h1, 6'd0, 1'b1);   // R8 overflow, R7 negative
        run_op(32'h5, 32'h5, 6'd1, 1'b1);           // R1 sub to zero
        run_op(32'h8000_0000, 32'h8000_0000, 6'd1, 1'b1); // R8 test on sub
        run_op(32'h1234_5678, 32'h0, 6'd3, 1'b1);   // R3 divide by zero
        run_op(32'd100, 32'd7, 6'd3, 1'b1);         // R3
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd2, 1'b1); // R2
        run_op(32'h8000_0001, 32'd31, 6'd8, 1'b1);  // R5
        run_op(32'h8000_0001, 32'd63, 6'd9, 1'b1);  // R5 uses B[4:0]
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd63, 1'b1); // R6
        run_op(32'h0, 32'h0, 6'd7, 1'b1);           // R4
        run_op(32'h0, 32'h0, 6'd4, 1'b0);           // R10 hold
        for (int s = 0; s < 32; s++) run_sel(5'(s)); // R12

        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic [5:0] c;
            c = ($urandom_range(0, 3) == 0) ? 6'($urandom_range(10, 63)) : 6'($urandom_range(0, 9));
            run_op(pick_word(), pick_word(), c, 1'($urandom_range(0, 3) != 0));
            run_sel(5'($urandom_range(0, 31)));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule